// File: doc/BRIEF.md
# Branch Target Lookup Table

This block is a small fully associative table that sits beside the instruction fetch stage. Each slot pairs an instruction address used as a key with a branch target and a 2-bit prediction value. Every clock, the fetch address is compared against all stored keys at once. The matching slot's target and prediction bit are captured in output registers.

Writes come through a separate update port. The update address is first searched among the keys. If it is already present, that slot is rewritten in place. If it is not present, the slot named by a circular replacement pointer is filled, and the pointer moves on.

Top module: `btb_lookup_table`

## Requirements
- R1: While `rst_n` is low at a rising edge, the table invalidates every slot, returns its replacement pointer to slot 0, and drives `lk_target` and `lk_taken` to zero one edge later. After reset, every lookup misses until a write is made.
- R2: When `lk_addr` equals the key of a valid slot at a rising edge, that slot's target appears on `lk_target` after that edge, with no further delay.
- R3: When no valid slot matches `lk_addr`, `lk_taken` is 0 and `lk_target` is all zeros after that edge.
- R4: `lk_taken` is bit 1 (the upper bit) of the matching slot's 2-bit `upd_val`. Values 2'b10 and 2'b11 predict taken; 2'b00 and 2'b01 predict not taken.
- R5: Addresses not already in the table are written to slots 0, 1, 2 and so on, in that order. After slot 15 the next new address overwrites slot 0, so the oldest key stops matching.
- R6: A write whose address is already a valid key replaces that slot's target and value, and does not use a new slot.
- R7: If a write and a lookup of the same address happen on the same edge, the lookup returns the contents from before the write. The new contents are visible from the next lookup.
- R8: The replacement pointer moves forward only when a new slot is allocated, and it wraps from the last slot to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_addr | input | ADDR_W | Fetch address to look up |
| lk_target | output | TGT_W | Registered branch target of the matching slot, zero on a miss |
| lk_taken | output | 1 | Registered prediction, the upper bit of the slot's value, zero on a miss |
| upd_en | input | 1 | Write strobe for the update port |
| upd_addr | input | ADDR_W | Key to write |
| upd_target | input | TGT_W | Branch target to store |
| upd_val | input | 2 | 2-bit prediction value to store |

## Verification
A lookup result is due exactly one rising edge after `lk_addr` is presented. A write is visible to lookups presented at any edge after the write edge. The bench changes inputs on falling edges and reads outputs 1 ns after the following rising edge, so each check sees only the edge it targets. The same-edge test presents the write and the lookup together. It reads the old contents after that edge, then the new contents one edge later.

// File: rtl/btb_pkg.sv
// Package: shared types and helpers for the branch target lookup table.
// Assumes a 2-bit prediction value whose upper bit is the taken prediction.
package btb_pkg;
    localparam int VAL_W = 2;
    typedef logic [VAL_W-1:0] pred_val_t;

    // Extract the taken prediction from a stored value.
    function automatic logic taken_of(input pred_val_t v);
        return v[VAL_W-1];
    endfunction
endpackage

// File: rtl/btb_match.sv
// Module: parallel key compare with a priority pick.
// Compares one address against every slot key and reports any hit and the
// lowest matching index. Assumes invalid slots must never match.
module btb_match #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [ADDR_W-1:0]  keys [ENTRIES],
    input  logic [ADDR_W-1:0]  addr,
    output logic [ENTRIES-1:0] match_vec,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    // One comparator per slot, gated by the valid bit.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid[g] && (keys[g] == addr);
    end

    // Priority encode: scan downward so the lowest match is kept last.
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |match_vec;
endmodule

// File: rtl/btb_store.sv
// Module: slot storage for keys, targets and prediction values.
// Only the valid bits are reset; slot data is meaningful only when valid.
module btb_store
    import btb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int TGT_W   = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [ADDR_W-1:0]  wkey,
    input  logic [TGT_W-1:0]   wtarget,
    input  pred_val_t          wval,
    output logic [ENTRIES-1:0] valid,
    output logic [ADDR_W-1:0]  keys    [ENTRIES],
    output logic [TGT_W-1:0]   targets [ENTRIES],
    output pred_val_t          vals    [ENTRIES]
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Valid bit: cleared by reset, set when this slot is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  valid[g] <= 1'b0;
            else if (we && widx == IDX_W'(g))            valid[g] <= 1'b1;
        end

        // Slot payload: loaded when this slot is the write target.
        always_ff @(posedge clk) begin
            if (we && widx == IDX_W'(g)) begin
                keys[g]    <= wkey;
                targets[g] <= wtarget;
                vals[g]    <= wval;
            end
        end
    end
endmodule

// File: rtl/btb_alloc_ptr.sv
// Module: circular replacement pointer.
// Advances by one on each allocation and wraps after the last slot.
module btb_alloc_ptr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Pointer update: reset to 0, step on allocation, wrap at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr <= '0;
        else if (advance)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/btb_lookup_table.sv
// Module: top of the fully associative branch target lookup table.
// A lookup is registered one edge after the address. A write searches the
// keys first and overwrites a matching slot; otherwise it allocates the
// slot at the replacement pointer. Same-edge lookups see the old contents.
module btb_lookup_table
    import btb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int TGT_W   = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [TGT_W-1:0]  lk_target,
    output logic              lk_taken,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [TGT_W-1:0]  upd_target,
    input  logic [1:0]        upd_val
);
    logic [ENTRIES-1:0] valid;
    logic [ADDR_W-1:0]  keys    [ENTRIES];
    logic [TGT_W-1:0]   targets [ENTRIES];
    pred_val_t          vals    [ENTRIES];

    logic [ENTRIES-1:0] lk_vec, upd_vec;
    logic               lk_hit, upd_hit;
    logic [IDX_W-1:0]   lk_idx, upd_idx, ptr, widx;
    logic               alloc;
    logic [TGT_W-1:0]   lk_pick_target;
    logic               lk_pick_taken;

    btb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lk_match (
        .valid(valid), .keys(keys), .addr(lk_addr),
        .match_vec(lk_vec), .hit(lk_hit), .idx(lk_idx)
    );

    btb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_upd_match (
        .valid(valid), .keys(keys), .addr(upd_addr),
        .match_vec(upd_vec), .hit(upd_hit), .idx(upd_idx)
    );

    // Write steering: reuse a matching slot, else take the pointer slot.
    always_comb begin
        alloc = upd_en && !upd_hit;
        widx  = upd_hit ? upd_idx : ptr;
    end

    btb_alloc_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .advance(alloc), .ptr(ptr)
    );

    btb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(upd_en), .widx(widx),
        .wkey(upd_addr), .wtarget(upd_target), .wval(upd_val),
        .valid(valid), .keys(keys), .targets(targets), .vals(vals)
    );

    // Read select: pick the matching slot's data, zero on a miss.
    always_comb begin
        lk_pick_target = lk_hit ? targets[lk_idx] : '0;
        lk_pick_taken  = lk_hit && taken_of(vals[lk_idx]);
    end

    // Output register: capture the lookup result every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_target <= '0;
            lk_taken  <= 1'b0;
        end else begin
            lk_target <= lk_pick_target;
            lk_taken  <= lk_pick_taken;
        end
    end
endmodule

// File: rtl/btb_lookup_table_chk.sv
// Module: assertion checker bound to the lookup table top.
// Observes the compare outputs, write steering and pointer over time.
module btb_lookup_table_chk #(
    parameter int ENTRIES = 16,
    parameter int TGT_W   = 32,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ENTRIES-1:0] lk_vec,
    input logic               lk_hit,
    input logic [TGT_W-1:0]   lk_pick_target,
    input logic               lk_pick_taken,
    input logic [TGT_W-1:0]   lk_target,
    input logic               lk_taken,
    input logic               upd_en,
    input logic [ENTRIES-1:0] upd_vec,
    input logic               alloc,
    input logic [IDX_W-1:0]   ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // R1: reset clears outputs and pointer by the next edge.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (lk_target == '0 && !lk_taken && ptr == '0));

    // R2: a hit's selected target is presented after the next edge.
    a_r2_hit_target: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> (lk_target == $past(lk_pick_target) && lk_taken == $past(lk_pick_taken)));

    // R3: a miss yields zero target and not-taken.
    a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |=> (lk_target == '0 && !lk_taken));

    // R6: keys stay unique, so at most one slot matches.
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec) && (!upd_en || $countones(upd_vec) <= 1));

    // R8: pointer holds when no allocation happens.
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc |=> $stable(ptr));

    // R8: pointer steps by one on allocation below the last slot.
    a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

    // R8: pointer wraps to slot 0 after the last slot.
    a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && ptr == LAST) |=> ptr == '0);
endmodule

bind btb_lookup_table btb_lookup_table_chk #(
    .ENTRIES(ENTRIES), .TGT_W(TGT_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_vec(lk_vec), .lk_hit(lk_hit),
    .lk_pick_target(lk_pick_target), .lk_pick_taken(lk_pick_taken),
    .lk_target(lk_target), .lk_taken(lk_taken), .upd_en(upd_en),
    .upd_vec(upd_vec), .alloc(alloc), .ptr(ptr)
);

// File: tb/btb_lookup_table_bench.sv
`timescale 1ns/1ps
module btb_lookup_table_bench;
    localparam int ADDR_W = 32;
    localparam int TGT_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic [TGT_W-1:0]  lk_target;
    logic              lk_taken;
    logic              upd_en = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic [TGT_W-1:0]  upd_target = '0;
    logic [1:0]        upd_val = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    btb_lookup_table u_btb_lookup_table (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
        .lk_target(lk_target), .lk_taken(lk_taken),
        .upd_en(upd_en), .upd_addr(upd_addr),
        .upd_target(upd_target), .upd_val(upd_val)
    );

    function automatic logic [ADDR_W-1:0] key_a(input int i);
        return 32'h0000_1000 + 32'(i * 4);
    endfunction

    task automatic expect_out(input string req, input logic [TGT_W-1:0] t, input logic tk);
        checks++;
        if (lk_target !== t || lk_taken !== tk) begin
            errors++;
            $display("FAIL %s: target=%h taken=%b expected target=%h taken=%b",
                     req, lk_target, lk_taken, t, tk);
        end
    endtask

    // Present a lookup, then check the registered result after the edge.
    task automatic lookup(input string req, input logic [ADDR_W-1:0] a,
                          input logic [TGT_W-1:0] t, input logic tk);
        @(negedge clk) lk_addr = a;
        @(posedge clk) #1;
        expect_out(req, t, tk);
    endtask

    task automatic write(input logic [ADDR_W-1:0] a, input logic [TGT_W-1:0] t,
                         input logic [1:0] v);
        @(negedge clk);
        upd_en = 1'b1; upd_addr = a; upd_target = t; upd_val = v;
        @(negedge clk) upd_en = 1'b0;
    endtask

    task automatic t_reset;
        @(posedge clk) #1;
        expect_out("R1 reset outputs", '0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        lookup("R1 empty after reset", 32'h0, '0, 1'b0);
        lookup("R3 miss on empty", key_a(0), '0, 1'b0);
    endtask

    // Fill all 16 slots with alternating taken/not-taken values.
    task automatic t_fill;
        for (int i = 0; i < 16; i++)
            write(key_a(i), 32'h8000_0000 + 32'(i), (i % 2 == 0) ? 2'b10 : 2'b01);
        for (int i = 0; i < 16; i++)
            lookup((i % 2 == 0) ? "R2 R4 hit taken" : "R2 R4 hit not taken",
                   key_a(i), 32'h8000_0000 + 32'(i), (i % 2 == 0));
        lookup("R3 miss unknown", 32'hDEAD_BEE0, '0, 1'b0);
    endtask

    // Overwrite an existing key, then allocate new ones past the wrap.
    task automatic t_overwrite_and_wrap;
        write(key_a(5), 32'h1234_5678, 2'b11);
        lookup("R6 overwrite in place", key_a(5), 32'h1234_5678, 1'b1);
        write(32'h0000_2000, 32'hB000_0000, 2'b00);
        lookup("R5 R8 wrap evicts slot 0", key_a(0), '0, 1'b0);
        lookup("R5 new entry hit", 32'h0000_2000, 32'hB000_0000, 1'b0);
        lookup("R6 no slot consumed, slot 1 kept", key_a(1), 32'h8000_0001, 1'b0);
        write(32'h0000_2004, 32'hB000_0001, 2'b10);
        lookup("R5 R8 next evicts slot 1", key_a(1), '0, 1'b0);
        lookup("R5 slot 2 kept", key_a(2), 32'h8000_0002, 1'b1);
        lookup("R6 overwritten slot kept", key_a(5), 32'h1234_5678, 1'b1);
    endtask

    // Write and look up the same key on one edge.
    task automatic t_same_edge;
        @(negedge clk);
        lk_addr = key_a(2);
        upd_en = 1'b1; upd_addr = key_a(2); upd_target = 32'hCAFE_0002; upd_val = 2'b01;
        @(posedge clk) #1;
        expect_out("R7 same edge returns old", 32'h8000_0002, 1'b1);
        @(negedge clk) upd_en = 1'b0;
        @(posedge clk) #1;
        expect_out("R7 next lookup returns new", 32'hCAFE_0002, 1'b0);
    endtask

    // Reset again mid-run: table must be empty.
    task automatic t_reset_again;
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk) #1;
        expect_out("R1 reset clears outputs", '0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        lookup("R1 entries invalid after reset", key_a(5), '0, 1'b0);
        write(32'h0000_3000, 32'hD000_0000, 2'b10);
        lookup("R1 R8 pointer restarted", 32'h0000_3000, 32'hD000_0000, 1'b1);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_overwrite_and_wrap();
        t_same_edge();
        t_reset_again();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule